// File: doc/BRIEF.md
# Single-Bit Alias Access Bridge

This block sits between one bus master and a single-port synchronous memory that holds 32-bit words. It watches every request for addresses that fall inside one of two alias windows, one mirroring a RAM region and one mirroring a peripheral-register region. Each alias address stands for exactly one bit of one backing word. A read through an alias window returns that bit alone, in bit 0 of the read data. A write through an alias window changes that bit alone. It does so with a locked read-modify-write of the backing word, so no other access can reach the memory between the read and the write-back.

Any address outside both windows goes to the memory unchanged as one read or one write. The master side is a valid/ready request port with a one-cycle response pulse. The bridge accepts one request at a time. The memory side assumes a read latency of one cycle.

The controller has five states. IDLE is the only state with ready high. On an accepted request it moves to WR for a plain write and to RD_REQ for anything else. RD_REQ issues a memory read and always moves to RD_WAIT. RD_WAIT captures the read data and moves to WR for an alias write, or to DONE otherwise. WR issues the memory write and always moves to DONE. DONE raises the response pulse and always returns to IDLE.

Top module: `bitband_bridge`

## Requirements
- R1: While reset is held and in the first cycle after it, `req_ready` is 1, `rsp_valid` is 0 and `mem_en` is 0.
- R2: An address A is an alias address of a window when A - ALIAS_BASE is below 128 * 2^SPAN_LOG2. The backing byte address is BACK_BASE + 4 * ((A - ALIAS_BASE) >> 7), and the bit number is A[6:2]. A[1:0] is ignored.
- R3: Two windows are decoded independently: a RAM window (RAM_ALIAS_BASE onto RAM_BASE) and a peripheral window (PER_ALIAS_BASE onto PER_BASE). If both match, the RAM window wins.
- R4: An alias read issues one memory read of the backing word. It returns the selected bit in `rsp_rdata[0]` with bits 31..1 zero, and it leaves memory unchanged.
- R5: An alias write takes the new bit value from `req_wdata[0]` only, ignoring bits 31..1. It writes back the backing word with every other bit equal to the value just read.
- R6: An alias write is exactly two memory cycles to the same address: a read, and two cycles later a write. The response comes in the cycle after the write-back.
- R7: A non-alias request is one memory cycle with `mem_addr` equal to `req_addr`. A write carries `req_wdata` unchanged. A read returns `mem_rdata` unchanged.
- R8: Each accepted request yields one single-cycle `rsp_valid` pulse. Counting the cycle after acceptance as cycle 1, the pulse comes in cycle 2 for a plain write, cycle 3 for any read, and cycle 4 for an alias write.
- R9: `req_ready` is high only while no request is in flight, and the memory is never accessed while `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Master presents a request |
| req_ready | output | 1 | Bridge can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address of the request |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read result, valid with `rsp_valid` on reads |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after a read strobe |

## Verification
The embedded assertions watch on every cycle that an alias write-back follows its read two cycles earlier at the same address. They also check that the write-back differs from the word just read in at most one bit, that an alias read result carries nothing above bit 0, that responses are single pulses, and that the memory is idle whenever ready is high. Only the bench scenarios can show the correctness of the values themselves: that the right bit of the right word is chosen in each window, that the ignored low address bits and upper write-data bits really have no effect, that the boundary address just past a window passes through, and the exact response latency per request kind.

// File: rtl/bb_pkg.sv
package bb_pkg;

    localparam int BB_AW    = 32;
    localparam int BB_DW    = 32;
    localparam int BB_BIT_W = $clog2(BB_DW);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_REQ,
        ST_RD_WAIT,
        ST_WR,
        ST_DONE
    } bb_state_e;

    typedef struct packed {
        logic                hit;
        logic [BB_AW-1:0]    back_addr;
        logic [BB_BIT_W-1:0] bit_idx;
    } bb_decode_t;

endpackage

// File: rtl/bb_window_decode.sv
module bb_window_decode
    import bb_pkg::*;
#(
    parameter logic [BB_AW-1:0] ALIAS_BASE = 32'h2200_0000,
    parameter logic [BB_AW-1:0] BACK_BASE  = 32'h2000_0000,
    parameter int               SPAN_LOG2  = 6
) (
    input  logic [BB_AW-1:0] addr,
    output bb_decode_t       dec
);
    // Each backing word owns 32 alias words of 4 bytes: 128 alias bytes.
    localparam int              WORD_SHIFT = BB_BIT_W + 2;
    localparam logic [BB_AW-1:0] SPAN_BYTES = BB_AW'(1) << (SPAN_LOG2 + WORD_SHIFT);

    logic [BB_AW-1:0] offset;
    logic [BB_AW-1:0] word_idx;

    always_comb begin
        offset        = addr - ALIAS_BASE;
        word_idx      = offset >> WORD_SHIFT;
        dec.hit       = (addr >= ALIAS_BASE) && (offset < SPAN_BYTES);
        dec.back_addr = BACK_BASE + (word_idx << 2);
        dec.bit_idx   = offset[WORD_SHIFT-1:2];
    end

endmodule

// File: rtl/bb_fsm.sv
module bb_fsm
    import bb_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      req_valid,
    input  logic      req_write,
    input  logic      req_alias,
    input  logic      op_write,
    input  logic      op_alias,
    output bb_state_e state,
    output logic      start,
    output logic      req_ready,
    output logic      mem_en,
    output logic      mem_we,
    output logic      rsp_valid
);
    bb_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (req_write && !req_alias) state_d = ST_WR;
                    else                         state_d = ST_RD_REQ;
                end
            end
            ST_RD_REQ:  state_d = ST_RD_WAIT;
            ST_RD_WAIT: state_d = (op_write && op_alias) ? ST_WR : ST_DONE;
            ST_WR:      state_d = ST_DONE;
            ST_DONE:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        req_ready = 1'b0;
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        rsp_valid = 1'b0;
        unique case (state_q)
            ST_IDLE:    req_ready = 1'b1;
            ST_RD_REQ:  mem_en    = 1'b1;
            ST_RD_WAIT: ;
            ST_WR: begin
                mem_en = 1'b1;
                mem_we = 1'b1;
            end
            ST_DONE:    rsp_valid = 1'b1;
            default:    ;
        endcase
    end

    assign state = state_q;
    assign start = req_valid && req_ready;

    // R8: the completion strobe never lasts more than one cycle
    a_r8_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R6: an alias write-back is preceded two cycles earlier by a read strobe
    a_r6_wb_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we && op_alias) |-> $past(mem_en && !mem_we, 2));

    // R6: completion follows the write strobe directly, still not ready
    a_r6_done_after_wb: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we) |=> (rsp_valid && !req_ready));

endmodule

// File: rtl/bb_datapath.sv
module bb_datapath
    import bb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  bb_state_e        state,
    input  bb_decode_t       dec,
    input  logic             req_write,
    input  logic [BB_AW-1:0] req_addr,
    input  logic [BB_DW-1:0] req_wdata,
    input  logic [BB_DW-1:0] mem_rdata,
    output logic             op_alias,
    output logic             op_write,
    output logic [BB_AW-1:0] mem_addr,
    output logic [BB_DW-1:0] mem_wdata,
    output logic [BB_DW-1:0] rsp_rdata
);
    logic [BB_AW-1:0]    op_addr;
    logic [BB_BIT_W-1:0] op_bit;
    logic [BB_DW-1:0]    op_wdata;
    logic [BB_DW-1:0]    rd_word;
    logic [BB_DW-1:0]    merged;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_alias  <= 1'b0;
            op_write  <= 1'b0;
            op_addr   <= '0;
            op_bit    <= '0;
            op_wdata  <= '0;
            rd_word   <= '0;
            rsp_rdata <= '0;
        end else if (start) begin
            op_alias  <= dec.hit;
            op_write  <= req_write;
            op_addr   <= dec.hit ? dec.back_addr : req_addr;
            op_bit    <= dec.bit_idx;
            op_wdata  <= req_wdata;
            rsp_rdata <= '0;
        end else if (state == ST_RD_WAIT) begin
            rd_word   <= mem_rdata;
            rsp_rdata <= op_alias ? {{(BB_DW-1){1'b0}}, mem_rdata[op_bit]} : mem_rdata;
        end
    end

    always_comb begin
        merged         = rd_word;
        merged[op_bit] = op_wdata[0];
    end

    assign mem_addr  = op_addr;
    assign mem_wdata = op_alias ? merged : op_wdata;

    // R5: the word written back differs from the word just read in at most one bit
    a_r5_single_bit_change: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WR && op_alias) |-> ($countones(mem_wdata ^ $past(mem_rdata)) <= 1));

    // R4: an alias read result carries nothing above bit 0
    a_r4_alias_rdata_narrow: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE && op_alias && !op_write) |-> (rsp_rdata[BB_DW-1:1] == '0));

endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge
    import bb_pkg::*;
#(
    parameter logic [31:0] RAM_BASE       = 32'h2000_0000,
    parameter logic [31:0] RAM_ALIAS_BASE = 32'h2200_0000,
    parameter logic [31:0] PER_BASE       = 32'h4000_0000,
    parameter logic [31:0] PER_ALIAS_BASE = 32'h4200_0000,
    parameter int          SPAN_LOG2      = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic        req_write,
    input  logic [31:0] req_addr,
    input  logic [31:0] req_wdata,
    output logic        rsp_valid,
    output logic [31:0] rsp_rdata,
    output logic        mem_en,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata
);
    localparam int NWIN = 2;

    bb_decode_t dec_win [NWIN];
    bb_decode_t dec_sel;
    bb_state_e  state;
    logic       start;
    logic       op_alias;
    logic       op_write;

    for (genvar w = 0; w < NWIN; w++) begin : g_win
        bb_window_decode #(
            .ALIAS_BASE (w == 0 ? RAM_ALIAS_BASE : PER_ALIAS_BASE),
            .BACK_BASE  (w == 0 ? RAM_BASE       : PER_BASE),
            .SPAN_LOG2  (SPAN_LOG2)
        ) u_dec (
            .addr (req_addr),
            .dec  (dec_win[w])
        );
    end

    // Lowest-numbered matching window wins
    always_comb begin
        dec_sel = '0;
        for (int w = NWIN - 1; w >= 0; w--) begin
            if (dec_win[w].hit) dec_sel = dec_win[w];
        end
    end

    bb_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_alias (dec_sel.hit),
        .op_write  (op_write),
        .op_alias  (op_alias),
        .state     (state),
        .start     (start),
        .req_ready (req_ready),
        .mem_en    (mem_en),
        .mem_we    (mem_we),
        .rsp_valid (rsp_valid)
    );

    bb_datapath u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .state     (state),
        .dec       (dec_sel),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .mem_rdata (mem_rdata),
        .op_alias  (op_alias),
        .op_write  (op_write),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .rsp_rdata (rsp_rdata)
    );

    // R9: no memory traffic while the bridge offers to accept a request
    a_r9_idle_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_en);

    // R6: write-back targets the address that was read
    a_r6_wb_same_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we && op_alias) |-> (mem_addr == $past(mem_addr, 2)));

    // R1: first cycle out of reset is idle
    a_r1_reset_idle: assert property (@(posedge clk)
        $rose(rst_n) |-> (req_ready && !rsp_valid && !mem_en));

endmodule

// File: tb/bitband_bridge_tb.sv
module bitband_bridge_tb;

    localparam logic [31:0] RAM_B  = 32'h2000_0000;
    localparam logic [31:0] RAM_AB = 32'h2200_0000;
    localparam logic [31:0] PER_B  = 32'h4000_0000;
    localparam logic [31:0] PER_AB = 32'h4200_0000;
    localparam logic [31:0] SPAN   = 32'd8192; // 64 words * 128

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        mem_en, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;

    always #5 clk = ~clk;

    bitband_bridge u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Slave memory, one-cycle read latency
    logic [31:0] ram_m [64];
    logic [31:0] per_m [64];
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) begin
                if (mem_addr[30]) per_m[mem_addr[7:2]] <= mem_wdata;
                else              ram_m[mem_addr[7:2]] <= mem_wdata;
            end else begin
                mem_rdata <= mem_addr[30] ? per_m[mem_addr[7:2]] : ram_m[mem_addr[7:2]];
            end
        end
    end

    // Shadow model
    logic [31:0] sh_ram [64];
    logic [31:0] sh_per [64];

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        logic        is_read;
        logic [31:0] rdata;
        int          at_cyc;
        int          ops;
        int          busy;
        logic [31:0] addr;
        logic        has_w;
        logic [31:0] wdata;
        string       req;
    } item_t;
    item_t q[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] sh_get(input logic [31:0] a);
        return a[30] ? sh_per[a[7:2]] : sh_ram[a[7:2]];
    endfunction

    task automatic sh_set(input logic [31:0] a, input logic [31:0] v);
        if (a[30]) sh_per[a[7:2]] = v;
        else       sh_ram[a[7:2]] = v;
    endtask

    task automatic do_req(input bit wr, input logic [31:0] a, input logic [31:0] wd,
                          input string req);
        item_t it;
        bit alias_hit;
        logic [31:0] back, w;
        int b, lat;
        alias_hit = 1'b0;
        back = a;
        b = int'(a[6:2]);
        if (a - RAM_AB < SPAN && a >= RAM_AB) begin
            alias_hit = 1'b1; back = RAM_B + (((a - RAM_AB) >> 7) << 2);
        end else if (a - PER_AB < SPAN && a >= PER_AB) begin
            alias_hit = 1'b1; back = PER_B + (((a - PER_AB) >> 7) << 2);
        end
        w = sh_get(back);
        it.is_read = !wr; it.addr = back; it.req = req; it.has_w = wr; it.wdata = '0; it.rdata = '0;
        if (alias_hit && !wr) begin
            it.rdata = {31'b0, w[b]}; lat = 2; it.ops = 1;
        end else if (alias_hit) begin
            w[b] = wd[0]; sh_set(back, w); it.wdata = w; lat = 3; it.ops = 2;
        end else if (!wr) begin
            it.rdata = w; lat = 2; it.ops = 1;
        end else begin
            sh_set(back, wd); it.wdata = wd; lat = 1; it.ops = 1;
        end
        it.busy = lat + 1;
        while (!req_ready) @(negedge clk);
        it.at_cyc = cyc + 1 + lat;
        q.push_back(it);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    // Monitor
    int   ops_seen = 0;
    int   busy_seen = 0;
    bit   addr_bad = 0;
    logic [31:0] bad_addr_v = '0;
    logic [31:0] w_seen = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!req_ready) busy_seen++;
            if (mem_en) begin
                ops_seen++;
                if (q.size() > 0 && mem_addr != q[0].addr) begin
                    addr_bad = 1; bad_addr_v = mem_addr;
                end
                if (mem_we) w_seen = mem_wdata;
            end
            if (rsp_valid) begin
                if (q.size() == 0) begin
                    chk(0, "R8", "unexpected response", 32'd1, 32'd0);
                end else begin
                    item_t it;
                    it = q.pop_front();
                    if (it.is_read) chk(rsp_rdata == it.rdata, it.req, "read data", rsp_rdata, it.rdata);
                    chk(cyc == it.at_cyc, "R8", "response cycle", cyc, it.at_cyc);
                    chk(ops_seen == it.ops, it.ops == 2 ? "R6" : it.req, "memory cycles", ops_seen, it.ops);
                    chk(!addr_bad, "R2", "memory address", bad_addr_v, it.addr);
                    chk(busy_seen == it.busy, "R9", "ready-low cycles", busy_seen, it.busy);
                    if (it.has_w) chk(w_seen == it.wdata, it.req, "written word", w_seen, it.wdata);
                end
                ops_seen = 0; busy_seen = 0; addr_bad = 0;
            end
        end
    end

    function automatic logic [31:0] ram_alias(input int word, input int b);
        return RAM_AB + 32'(word * 128) + 32'(b * 4);
    endfunction
    function automatic logic [31:0] per_alias(input int word, input int b);
        return PER_AB + 32'(word * 128) + 32'(b * 4);
    endfunction

    initial begin
        for (int i = 0; i < 64; i++) begin
            ram_m[i] = 32'(i) * 32'h9E37_79B9;
            per_m[i] = ~(32'(i) * 32'h85EB_CA6B);
            sh_ram[i] = ram_m[i];
            sh_per[i] = per_m[i];
        end
        repeat (3) @(negedge clk);
        // R1: values while reset is held
        chk(req_ready == 1'b1, "R1", "ready in reset", {31'b0, req_ready}, 32'd1);
        chk(rsp_valid == 1'b0, "R1", "rsp_valid in reset", {31'b0, rsp_valid}, 32'd0);
        chk(mem_en == 1'b0, "R1", "mem_en in reset", {31'b0, mem_en}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !rsp_valid && !mem_en, "R1", "idle after reset",
            {29'b0, req_ready, rsp_valid, mem_en}, 32'd4);

        // R7: plain accesses
        do_req(0, RAM_B + 32'd12, '0, "R7");
        do_req(0, PER_B + 32'd20, '0, "R7");
        // R4 / R2: alias reads of several bits
        do_req(0, ram_alias(3, 0), '0, "R4");
        do_req(0, ram_alias(3, 31), '0, "R4");
        do_req(0, ram_alias(3, 7), '0, "R4");
        // R5: set then clear a bit, upper write-data bits ignored
        do_req(1, ram_alias(3, 5), 32'h0000_0001, "R5");
        do_req(0, RAM_B + 32'd12, '0, "R5");
        do_req(1, ram_alias(3, 5), 32'hFFFF_FFFE, "R5");
        do_req(0, RAM_B + 32'd12, '0, "R5");
        // R2: low address bits ignored
        do_req(0, ram_alias(10, 4) | 32'd3, '0, "R2");
        do_req(1, ram_alias(10, 4) | 32'd2, 32'd1, "R2");
        do_req(0, RAM_B + 32'd40, '0, "R2");
        // R3: peripheral window, last word and last bit
        do_req(1, per_alias(63, 31), 32'd1, "R3");
        do_req(0, PER_B + 32'd252, '0, "R3");
        do_req(0, per_alias(63, 31), '0, "R3");
        do_req(1, per_alias(0, 0), 32'd0, "R3");
        do_req(0, PER_B, '0, "R3");
        // R7: address just past the RAM window is passed through
        do_req(0, RAM_AB + SPAN, '0, "R7");
        do_req(1, RAM_B + 32'd80, 32'hDEAD_BEEF, "R7");
        do_req(0, ram_alias(20, 0), '0, "R4");
        do_req(0, ram_alias(20, 1), '0, "R4");
        // R6: back-to-back alias writes to one word
        for (int k = 0; k < 8; k++)
            do_req(1, per_alias(2, (k * 7) % 32), 32'(k & 1), "R6");
        do_req(0, PER_B + 32'd8, '0, "R6");
        while (q.size() != 0) @(negedge clk);
        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule